// File: doc/BRIEF.md
# SPI Configuration Register Bank

This block is a serial slave that turns 16-bit serial words into reads and writes of a small bank of acquisition settings. The bank holds a presample count, an event-size code, an LED control field and a test-pattern send control. It also reads back a measured frequency count and two test-pattern health flags that arrive from neighbouring logic. Writing to the flag address does not store anything. Instead it fires a one-cycle strobe that re-arms the flags in the checker that owns them.

The same serial bus also serves an external ADC. A route-select input decides where the bus goes. When it is 1, the bank answers and the ADC pins are parked idle. When it is 0, chip select, serial clock and data pass straight through to the ADC, the ADC's read data returns to the host, and the bank ignores the traffic.

The serial pins are oversampled by the block clock through synchronizers. Each serial half period must therefore last at least SYNC_STAGES + 3 clock cycles. `route_sel`, `freq_count` and the flag inputs are taken to be synchronous to `clk`.

Top module: `cfg_spi_bank`

## Requirements
- R1: A frame is 16 bits, MSB first, sampled on rising edges of `spi_sclk_n`. Bits [15:13] are the address, bit [12] is 1 for write and 0 for read, and bits [11:0] are data. A write to address 0 sets `presample` to data[9:0].
- R2: A write to address 1 sets `event_size` to data[2:0]. A write to address 2 sets `led_ctrl` to data[6:0]. A write to address 3 sets `tp_send` to data[1:0]. Higher data bits are ignored.
- R3: In a read frame, the 12-bit read value is shifted out MSB first on `spi_miso` during frame bits 4..15. Each bit changes after a falling edge of `spi_sclk_n`. The read values are:
  - addresses 0..3: the stored field, zero-extended;
  - address 4: `freq_count`;
  - address 5: {10'b0, `tp_ok_ramp`, `tp_ok_alt`};
  - addresses 6 and 7: zero.
  Read frames change no field.
- R4: Any complete write to address 5 gives exactly one `tp_rearm` pulse, one clock wide, whatever the data. It stores nothing.
- R5: A frame with fewer or more than 16 serial clocks changes no field and gives no `tp_rearm` pulse.
- R6: A write takes effect only after `spi_cs_n` rises. Fields hold their old values after all 16 clocks while chip select is still low.
- R7: With route 1, `spi_miso` is 0 during the first four frame bits, throughout write frames, and while chip select is high.
- R8: With `route_sel` = 0, the ADC pins follow the host pins:
  - `adc_cs_n` follows `spi_cs_n`;
  - `adc_sclk_n` follows `spi_sclk_n`;
  - `adc_mosi` follows `spi_mosi`;
  - `spi_miso` follows `adc_miso`.
  Frames in this state change no field and give no `tp_rearm` pulse.
- R9: With `route_sel` = 1, the ADC pins are parked idle: `adc_cs_n` = 1, `adc_sclk_n` = 1 and `adc_mosi` = 0.
- R10: After reset, all fields are zero and `tp_rearm` and `spi_miso` are 0.
- R11: Writes to addresses 4, 6 and 7 change no field and give no `tp_rearm` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| route_sel | input | 1 | 1 = bus to this bank, 0 = bus to the ADC |
| spi_cs_n | input | 1 | Host chip select, active low |
| spi_sclk_n | input | 1 | Host serial clock, idle high |
| spi_mosi | input | 1 | Host serial data in |
| spi_miso | output | 1 | Serial read data back to the host |
| adc_cs_n | output | 1 | Chip select toward the ADC |
| adc_sclk_n | output | 1 | Serial clock toward the ADC |
| adc_mosi | output | 1 | Serial data toward the ADC |
| adc_miso | input | 1 | Serial read data from the ADC |
| freq_count | input | FREQ_W | Measured frequency count, read at address 4 |
| tp_ok_ramp | input | 1 | Ramp-pattern health flag, read at address 5 bit 1 |
| tp_ok_alt | input | 1 | Alternating-pattern health flag, read at address 5 bit 0 |
| presample | output | PRESAMPLE_W | Presample setting |
| event_size | output | EVSZ_W | Event-size code |
| led_ctrl | output | LED_W | LED control field |
| tp_send | output | TPSEND_W | Test-pattern send control |
| tp_rearm | output | 1 | One-cycle strobe on a write to address 5 |

## Verification
A wrong bit counter shows up in two ways at the ports. Writes commit on 15- or 17-clock frames, or read data comes out one bit early or late; the next frame shows either within a few hundred clocks. A wrongly latched header decodes the wrong field. This is seen on the field outputs about four clocks after chip select rises, and as a mismatched read-back word in the following read. A route gate that leaks shows up as a field change or a stray `tp_rearm` pulse right after a frame sent with route 0.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;
   // register addresses inside the bank
   localparam int unsigned A_PRESAMPLE = 0;
   localparam int unsigned A_EVSIZE    = 1;
   localparam int unsigned A_LED       = 2;
   localparam int unsigned A_TPSEND    = 3;
   localparam int unsigned A_FREQ      = 4;
   localparam int unsigned A_TPFLAGS   = 5;
   // number of writable fields, mapped at addresses 0 .. N_FIELDS-1
   localparam int unsigned N_FIELDS    = 4;
   // serial pin idle levels
   localparam logic CS_IDLE   = 1'b1;
   localparam logic SCLK_IDLE = 1'b1;
   localparam logic MOSI_IDLE = 1'b0;
endpackage

// File: rtl/cfg_spi_sync.sv
module cfg_spi_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 0) begin : g_bad_stages
      $error("cfg_spi_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
         end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
         end
      end
      assign q = chain[STAGES-1];
   end
endmodule

// File: rtl/cfg_spi_frame.sv
module cfg_spi_frame #(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_s,
   input  logic              sclk_n_s,
   input  logic              mosi_s,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_data,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              miso
);
   localparam int HDR_W  = ADDR_W + 1;
   localparam int WORD_W = HDR_W + DATA_W;
   localparam int CNT_W  = $clog2(WORD_W + 2);
   localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

   if (DATA_W < HDR_W) begin : g_bad_data
      $error("cfg_spi_frame: DATA_W must hold the header bits");
   end

   logic              cs_q, sclk_q;
   logic              cs_rise, sclk_rise, sclk_fall;
   logic [DATA_W-1:0] sr;
   logic [DATA_W-1:0] rd_sr;
   logic [CNT_W-1:0]  cnt;
   logic              load_pend;
   logic              hdr_rw;
   logic [ADDR_W-1:0] hdr_addr;

   assign cs_rise   = cs_n_s & ~cs_q;
   assign sclk_rise = sclk_n_s & ~sclk_q;
   assign sclk_fall = ~sclk_n_s & sclk_q;
   // header sits in the low bits right after the fourth sample
   assign rd_addr   = sr[ADDR_W:1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q      <= 1'b1;
         sclk_q    <= 1'b1;
         sr        <= '0;
         rd_sr     <= '0;
         cnt       <= '0;
         load_pend <= 1'b0;
         hdr_rw    <= 1'b0;
         hdr_addr  <= '0;
         wr_valid  <= 1'b0;
         wr_addr   <= '0;
         wr_data   <= '0;
         miso      <= 1'b0;
      end else begin
         cs_q      <= cs_n_s;
         sclk_q    <= sclk_n_s;
         load_pend <= 1'b0;
         wr_valid  <= 1'b0;
         if (cs_rise && cnt == CNT_FULL && hdr_rw) begin
            wr_valid <= 1'b1;
            wr_addr  <= hdr_addr;
            wr_data  <= sr;
         end
         if (cs_n_s) begin
            cnt    <= '0;
            miso   <= 1'b0;
            rd_sr  <= '0;
            hdr_rw <= 1'b0;
         end else begin
            if (sclk_fall) begin
               if (cnt >= CNT_HDR && cnt < CNT_FULL) begin
                  miso  <= rd_sr[DATA_W-1];
                  rd_sr <= {rd_sr[DATA_W-2:0], 1'b0};
               end else begin
                  miso <= 1'b0;
               end
            end
            if (load_pend) begin
               hdr_addr <= sr[ADDR_W:1];
               hdr_rw   <= sr[0];
               rd_sr    <= sr[0] ? '0 : rd_data;
            end
            if (sclk_rise) begin
               sr <= {sr[DATA_W-2:0], mosi_s};
               if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
               if (cnt == CNT_HDR - 1'b1) load_pend <= 1'b1;
            end
         end
      end
   end

   AST_FRAME_LEN_16: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> $past(cnt) == CNT_FULL); // R5
   AST_WRITE_AFTER_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> $past(cs_n_s) && !$past(cs_n_s, 2)); // R6
   AST_HDR_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n_s && cnt < CNT_HDR) |-> !miso); // R7
   AST_IDLE_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cs_n_s) |-> !miso); // R7
endmodule

// File: rtl/cfg_spi_regs.sv
module cfg_spi_regs
   import cfg_spi_pkg::*;
#(
   parameter int ADDR_W      = 3,
   parameter int DATA_W      = 12,
   parameter int PRESAMPLE_W = 10,
   parameter int EVSZ_W      = 3,
   parameter int LED_W       = 7,
   parameter int TPSEND_W    = 2,
   parameter int FREQ_W      = 12
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   route_ok,
   input  logic                   wr_valid,
   input  logic [ADDR_W-1:0]      wr_addr,
   input  logic [DATA_W-1:0]      wr_data,
   input  logic [ADDR_W-1:0]      rd_addr,
   output logic [DATA_W-1:0]      rd_data,
   input  logic [FREQ_W-1:0]      freq_count,
   input  logic                   tp_ok_ramp,
   input  logic                   tp_ok_alt,
   output logic [PRESAMPLE_W-1:0] presample,
   output logic [EVSZ_W-1:0]      event_size,
   output logic [LED_W-1:0]       led_ctrl,
   output logic [TPSEND_W-1:0]    tp_send,
   output logic                   tp_rearm
);
   localparam int FW [N_FIELDS] = '{PRESAMPLE_W, EVSZ_W, LED_W, TPSEND_W};

   if (ADDR_W < 3) begin : g_bad_addr
      $error("cfg_spi_regs: ADDR_W must reach address 5");
   end
   if (FREQ_W > DATA_W) begin : g_bad_freq
      $error("cfg_spi_regs: FREQ_W wider than DATA_W");
   end

   logic              commit;
   logic [DATA_W-1:0] fld_rd [N_FIELDS];
   logic              unused_bits;

   assign commit      = wr_valid & route_ok;
   assign unused_bits = ^wr_data;

   for (genvar i = 0; i < N_FIELDS; i++) begin : g_fld
      localparam int W = FW[i];
      if (W < 1 || W > DATA_W) begin : g_bad_w
         $error("cfg_spi_regs: field width out of range");
      end
      logic [W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   q <= '0;
         else if (commit && wr_addr == ADDR_W'(i))     q <= wr_data[W-1:0];
      end
      assign fld_rd[i] = DATA_W'(q);
   end

   assign presample  = g_fld[0].q;
   assign event_size = g_fld[1].q;
   assign led_ctrl   = g_fld[2].q;
   assign tp_send    = g_fld[3].q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tp_rearm <= 1'b0;
      else        tp_rearm <= commit && wr_addr == ADDR_W'(A_TPFLAGS);
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr < ADDR_W'(N_FIELDS))             rd_data = fld_rd[rd_addr[1:0]];
      else if (rd_addr == ADDR_W'(A_FREQ))         rd_data = DATA_W'(freq_count);
      else if (rd_addr == ADDR_W'(A_TPFLAGS))      rd_data = DATA_W'({tp_ok_ramp, tp_ok_alt});
   end

   AST_REARM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      tp_rearm |=> !tp_rearm); // R4
   AST_REARM_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      tp_rearm |-> $stable(presample) && $stable(event_size) && $stable(led_ctrl) && $stable(tp_send)); // R4
   AST_UNROUTED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !route_ok |=> $stable(presample) && $stable(event_size) && $stable(led_ctrl) && $stable(tp_send)); // R8
endmodule

// File: rtl/cfg_spi_route.sv
module cfg_spi_route
   import cfg_spi_pkg::*;
(
   input  logic route_sel,
   input  logic spi_cs_n,
   input  logic spi_sclk_n,
   input  logic spi_mosi,
   input  logic bank_miso,
   input  logic adc_miso,
   output logic spi_miso,
   output logic adc_cs_n,
   output logic adc_sclk_n,
   output logic adc_mosi,
   output logic bank_cs_n
);
   assign adc_cs_n   = route_sel ? CS_IDLE   : spi_cs_n;
   assign adc_sclk_n = route_sel ? SCLK_IDLE : spi_sclk_n;
   assign adc_mosi   = route_sel ? MOSI_IDLE : spi_mosi;
   assign spi_miso   = route_sel ? bank_miso : adc_miso;
   assign bank_cs_n  = spi_cs_n | ~route_sel;
endmodule

// File: rtl/cfg_spi_bank.sv
module cfg_spi_bank
   import cfg_spi_pkg::*;
#(
   parameter int ADDR_W      = 3,
   parameter int DATA_W      = 12,
   parameter int SYNC_STAGES = 2,
   parameter int PRESAMPLE_W = 10,
   parameter int EVSZ_W      = 3,
   parameter int LED_W       = 7,
   parameter int TPSEND_W    = 2,
   parameter int FREQ_W      = 12
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   route_sel,
   input  logic                   spi_cs_n,
   input  logic                   spi_sclk_n,
   input  logic                   spi_mosi,
   output logic                   spi_miso,
   output logic                   adc_cs_n,
   output logic                   adc_sclk_n,
   output logic                   adc_mosi,
   input  logic                   adc_miso,
   input  logic [FREQ_W-1:0]      freq_count,
   input  logic                   tp_ok_ramp,
   input  logic                   tp_ok_alt,
   output logic [PRESAMPLE_W-1:0] presample,
   output logic [EVSZ_W-1:0]      event_size,
   output logic [LED_W-1:0]       led_ctrl,
   output logic [TPSEND_W-1:0]    tp_send,
   output logic                   tp_rearm
);
   logic              bank_cs_n, bank_miso;
   logic              cs_s, sclk_s, mosi_s;
   logic [ADDR_W-1:0] rd_addr, wr_addr;
   logic [DATA_W-1:0] rd_data, wr_data;
   logic              wr_valid;

   cfg_spi_route u_route (
      .route_sel (route_sel),  .spi_cs_n  (spi_cs_n),   .spi_sclk_n(spi_sclk_n),
      .spi_mosi  (spi_mosi),   .bank_miso (bank_miso),  .adc_miso  (adc_miso),
      .spi_miso  (spi_miso),   .adc_cs_n  (adc_cs_n),   .adc_sclk_n(adc_sclk_n),
      .adc_mosi  (adc_mosi),   .bank_cs_n (bank_cs_n)
   );

   cfg_spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(CS_IDLE)) u_sync_cs (
      .clk(clk), .rst_n(rst_n), .d(bank_cs_n), .q(cs_s));
   cfg_spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(SCLK_IDLE)) u_sync_sclk (
      .clk(clk), .rst_n(rst_n), .d(spi_sclk_n), .q(sclk_s));
   cfg_spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(MOSI_IDLE)) u_sync_mosi (
      .clk(clk), .rst_n(rst_n), .d(spi_mosi), .q(mosi_s));

   cfg_spi_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .cs_n_s(cs_s), .sclk_n_s(sclk_s), .mosi_s(mosi_s),
      .rd_addr(rd_addr), .rd_data(rd_data), .wr_valid(wr_valid),
      .wr_addr(wr_addr), .wr_data(wr_data), .miso(bank_miso)
   );

   cfg_spi_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRESAMPLE_W(PRESAMPLE_W), .EVSZ_W(EVSZ_W),
      .LED_W(LED_W), .TPSEND_W(TPSEND_W), .FREQ_W(FREQ_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .route_ok(route_sel), .wr_valid(wr_valid),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .freq_count(freq_count), .tp_ok_ramp(tp_ok_ramp), .tp_ok_alt(tp_ok_alt),
      .presample(presample), .event_size(event_size), .led_ctrl(led_ctrl),
      .tp_send(tp_send), .tp_rearm(tp_rearm)
   );
endmodule

// File: tb/tb_cfg_spi_bank.sv
module tb_cfg_spi_bank;
   localparam int HALF = 8;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        route_sel, spi_cs_n, spi_sclk_n, spi_mosi;
   logic        spi_miso, adc_cs_n, adc_sclk_n, adc_mosi, adc_miso;
   logic [11:0] freq_count;
   logic        tp_ok_ramp, tp_ok_alt;
   logic [9:0]  presample;
   logic [2:0]  event_size;
   logic [6:0]  led_ctrl;
   logic [1:0]  tp_send;
   logic        tp_rearm;

   int checks = 0, failures = 0;
   int rearm_cnt = 0, rearm_hi = 0, rearm_exp = 0;
   logic rearm_q = 1'b0;

   logic [9:0] m_pre; logic [2:0] m_evsz; logic [6:0] m_led; logic [1:0] m_tps;

   always #10 clk = ~clk;
   assign adc_miso = ~spi_mosi;

   cfg_spi_bank dut (
      .clk(clk), .rst_n(rst_n), .route_sel(route_sel), .spi_cs_n(spi_cs_n),
      .spi_sclk_n(spi_sclk_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
      .adc_cs_n(adc_cs_n), .adc_sclk_n(adc_sclk_n), .adc_mosi(adc_mosi),
      .adc_miso(adc_miso), .freq_count(freq_count), .tp_ok_ramp(tp_ok_ramp),
      .tp_ok_alt(tp_ok_alt), .presample(presample), .event_size(event_size),
      .led_ctrl(led_ctrl), .tp_send(tp_send), .tp_rearm(tp_rearm)
   );

   always @(posedge clk) begin
      rearm_q <= tp_rearm;
      if (tp_rearm) rearm_hi <= rearm_hi + 1;
      if (tp_rearm && !rearm_q) rearm_cnt <= rearm_cnt + 1;
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic chk_fields(input string tag);
      chk(presample == m_pre, {tag, " presample"}, 32'(presample), 32'(m_pre));
      chk(event_size == m_evsz, {tag, " event_size"}, 32'(event_size), 32'(m_evsz));
      chk(led_ctrl == m_led, {tag, " led_ctrl"}, 32'(led_ctrl), 32'(m_led));
      chk(tp_send == m_tps, {tag, " tp_send"}, 32'(tp_send), 32'(m_tps));
   endtask

   task automatic xfer(input logic [15:0] word, input int nbits, input bit hold_chk,
                       output logic [11:0] rd);
      rd = '0;
      @(negedge clk) spi_cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         spi_sclk_n = 1'b0;
         spi_mosi   = (i < 16) ? word[15-i] : 1'b0;
         repeat (HALF) @(negedge clk);
         if (i >= 4 && i < 16) rd[15-i] = spi_miso;
         if (route_sel) begin
            if (i < 4) chk(spi_miso == 1'b0, "R7 header miso", 32'(spi_miso), 0);
            if (i == 0) chk(adc_cs_n && adc_sclk_n && !adc_mosi, "R9 adc parked",
                            {29'd0, adc_cs_n, adc_sclk_n, adc_mosi}, 32'b110);
         end else begin
            chk(!adc_cs_n && !adc_sclk_n && adc_mosi == spi_mosi && spi_miso == adc_miso,
                "R8 pass-through", {28'd0, adc_cs_n, adc_sclk_n, adc_mosi, spi_miso},
                {28'd0, 2'b00, spi_mosi, adc_miso});
         end
         spi_sclk_n = 1'b1;
         repeat (HALF) @(negedge clk);
      end
      if (hold_chk) chk_fields("R6 hold before cs rise");
      spi_cs_n = 1'b1;
      repeat (3 * HALF) @(negedge clk);
      chk(spi_miso == 1'b0 || !route_sel, "R7 idle miso", 32'(spi_miso), 0);
   endtask

   initial begin
      logic [11:0] rd, data, exp;
      rst_n = 1'b0; route_sel = 1'b1; spi_cs_n = 1'b1; spi_sclk_n = 1'b1; spi_mosi = 1'b0;
      freq_count = '0; tp_ok_ramp = 1'b0; tp_ok_alt = 1'b0;
      m_pre = '0; m_evsz = '0; m_led = '0; m_tps = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk_fields("R10 reset");
      chk(!tp_rearm && !spi_miso, "R10 reset strobes", {30'd0, tp_rearm, spi_miso}, 0);

      // sweep: write every address, then read every address back
      for (int k = 0; k < 6; k++) begin
         freq_count = 12'hA5C ^ 12'(k * 12'h1F3);
         tp_ok_ramp = k[0];
         tp_ok_alt  = k[1] ^ k[0];
         for (int a = 0; a < 8; a++) begin
            data = 12'(k * 12'h6B5 + a * 12'h2C9 + 12'h813);
            xfer({3'(a), 1'b1, data}, 16, 1'b1, rd);
            chk(rd == 12'h000, "R7 write frame miso", 32'(rd), 0);
            case (a)
               0: m_pre  = data[9:0];
               1: m_evsz = data[2:0];
               2: m_led  = data[6:0];
               3: m_tps  = data[1:0];
               5: rearm_exp++;
               default: ;
            endcase
            if (a == 0)      chk_fields("R1 write");
            else if (a < 4)  chk_fields("R2 write");
            else if (a == 5) chk_fields("R4 no store");
            else             chk_fields("R11 ignored write");
            chk(rearm_cnt == rearm_exp, "R4 rearm count", 32'(rearm_cnt), 32'(rearm_exp));
         end
         for (int r = 0; r < 8; r++) begin
            xfer({3'(r), 1'b0, ~12'(r * 12'h3A1)}, 16, 1'b0, rd);
            case (r)
               0: exp = 12'(m_pre);
               1: exp = 12'(m_evsz);
               2: exp = 12'(m_led);
               3: exp = 12'(m_tps);
               4: exp = freq_count;
               5: exp = {10'd0, tp_ok_ramp, tp_ok_alt};
               default: exp = 12'h000;
            endcase
            chk(rd == exp, "R3 read back", 32'(rd), 32'(exp));
         end
         chk_fields("R3 reads change nothing");
      end
      chk(rearm_hi == rearm_cnt, "R4 pulse width", 32'(rearm_hi), 32'(rearm_cnt));

      // wrong-length frames
      xfer({3'd0, 1'b1, 12'h2A5}, 15, 1'b0, rd);
      chk_fields("R5 short frame");
      xfer({3'd2, 1'b1, 12'h05A}, 17, 1'b0, rd);
      chk_fields("R5 long frame");
      xfer({3'd5, 1'b1, 12'hFFF}, 15, 1'b0, rd);
      xfer({3'd5, 1'b1, 12'h000}, 17, 1'b0, rd);
      chk(rearm_cnt == rearm_exp, "R5 no rearm", 32'(rearm_cnt), 32'(rearm_exp));

      // bus routed to the ADC
      route_sel = 1'b0;
      repeat (4) @(negedge clk);
      chk(adc_cs_n == spi_cs_n && adc_sclk_n == spi_sclk_n, "R8 idle follow",
          {30'd0, adc_cs_n, adc_sclk_n}, {30'd0, spi_cs_n, spi_sclk_n});
      xfer({3'd1, 1'b1, 12'h005}, 16, 1'b0, rd);
      xfer({3'd5, 1'b1, 12'h123}, 16, 1'b0, rd);
      chk_fields("R8 bank ignores");
      chk(rearm_cnt == rearm_exp, "R8 no rearm", 32'(rearm_cnt), 32'(rearm_exp));
      route_sel = 1'b1;
      repeat (4) @(negedge clk);
      xfer({3'd3, 1'b1, 12'hABE}, 16, 1'b1, rd);
      m_tps = 2'b10;
      chk_fields("R2 after reroute");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule